// File: doc/BRIEF.md
# Alternating Obstacle Turn Controller

This block is a small clocked Mealy state machine that turns a mobile platform away from obstacles. Each cycle it looks at a one-bit obstacle flag and drives a two-bit turn command. The command is a function of the present state and the present flag, so it follows the flag within the same cycle. The state changes only on the rising clock edge.

The machine stores two things: whether the platform is turning now, and which way it turned last. A flag that stays high keeps the current turn going. Once the flag drops, the next obstacle is taken in the other direction. Successive separate obstacles are therefore handled right, left, right, and so on.

An active-low asynchronous reset and a synchronous clear both return the machine to its home state: clear path, last turn left. The first obstacle after either one is therefore taken as a right turn.

Top module: `obst_steer_ctrl`

## Requirements
- R1: While `rst_ni` is low, the state is home (clear path, last turn left) at once, without waiting for a clock edge. In that state an obstacle (`obstacle_i`=1) drives `turn_o`=01, a right turn.
- R2: `turn_o` never shows the unused code 11. The command codes are 00 for no turn, 01 for right and 10 for left.
- R3: With `obstacle_i`=0, `turn_o` is 00 whatever the state.
- R4: From home, an obstacle drives a right turn (01) in the same cycle. After the edge the machine is in the turning-right state.
- R5: While turning right, a sustained obstacle keeps `turn_o`=01 and keeps the state.
- R6: When the obstacle goes away while turning right, the machine moves to a clear state that records a right turn. The next obstacle then drives a left turn (10).
- R7: While turning left, a sustained obstacle keeps `turn_o`=10. When that obstacle goes away, the machine returns home, and the next obstacle drives a right turn again.
- R8: `clr_i`=1 at a rising edge makes the next state home, whatever the state and whatever `obstacle_i` is. During the clear cycle itself, `turn_o` still follows the present state and `obstacle_i`.
- R9: `turn_o` follows a change on `obstacle_i` within the same cycle, with no clock edge needed (Mealy output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, to the home state |
| clr_i | input | 1 | Synchronous clear to the home state |
| obstacle_i | input | 1 | 1 = obstacle present, 0 = path clear |
| turn_o | output | 2 | Turn command: 00 none, 01 right, 10 left |

## Verification
A wrong state can stay hidden while the path is clear, because every state drives 00 when the flag is low. It shows up in the very first cycle in which `obstacle_i` is high, as a wrong turn direction or as a turn where none is expected. The bench therefore raises the flag often, using both isolated pulses and long runs. It compares `turn_o` with a behavioural model in every cycle. It also places clears and resets inside obstacle runs, so that a missed return to home appears as a left turn where a right one is due.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int unsigned STATE_W = 2;
  localparam int unsigned CMD_W   = 2;

  // codes chosen so neighbouring states differ in one bit
  typedef enum logic [STATE_W-1:0] {
    ST_HOME   = 2'b00,  // clear, last turn left
    ST_TURN_R = 2'b01,
    ST_CLR_R  = 2'b11,  // clear, last turn right
    ST_TURN_L = 2'b10
  } steer_state_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 2'b00,
    CMD_RIGHT = 2'b01,
    CMD_LEFT  = 2'b10
  } turn_cmd_e;
endpackage

// File: rtl/steer_next_state.sv
module steer_next_state
  import steer_pkg::*;
(
  input  steer_state_e state_i,
  input  logic         obstacle_i,
  input  logic         clr_i,
  output steer_state_e state_next_o
);
  steer_state_e step;

  always_comb begin
    unique case (state_i)
      ST_HOME:   step = obstacle_i ? ST_TURN_R : ST_HOME;
      ST_TURN_R: step = obstacle_i ? ST_TURN_R : ST_CLR_R;
      ST_CLR_R:  step = obstacle_i ? ST_TURN_L : ST_CLR_R;
      ST_TURN_L: step = obstacle_i ? ST_TURN_L : ST_HOME;
      default:   step = ST_HOME;
    endcase
  end

  assign state_next_o = clr_i ? ST_HOME : step;
endmodule

// File: rtl/steer_turn_decode.sv
module steer_turn_decode
  import steer_pkg::*;
(
  input  steer_state_e state_i,
  input  logic         obstacle_i,
  output turn_cmd_e    turn_o
);
  always_comb begin
    turn_o = CMD_NONE;
    if (obstacle_i) begin
      unique case (state_i)
        ST_HOME, ST_TURN_R: turn_o = CMD_RIGHT;
        ST_CLR_R, ST_TURN_L: turn_o = CMD_LEFT;
        default:             turn_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/steer_state_reg.sv
module steer_state_reg
  import steer_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  steer_state_e state_next_i,
  output steer_state_e state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_HOME;
    else         state_o <= state_next_i;
  end
endmodule

// File: rtl/obst_steer_ctrl.sv
module obst_steer_ctrl
  import steer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             obstacle_i,
  output logic [CMD_W-1:0] turn_o
);
  steer_state_e state_q, state_d;
  turn_cmd_e    cmd;

  steer_next_state u_next (
    .state_i      (state_q),
    .obstacle_i   (obstacle_i),
    .clr_i        (clr_i),
    .state_next_o (state_d)
  );

  steer_state_reg u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_next_i (state_d),
    .state_o      (state_q)
  );

  steer_turn_decode u_dec (
    .state_i    (state_q),
    .obstacle_i (obstacle_i),
    .turn_o     (cmd)
  );

  assign turn_o = cmd;

  assert_no_code3_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_o != 2'b11);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obstacle_i |-> turn_o == CMD_NONE);

  assert_home_to_right_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOME && obstacle_i && !clr_i) |=> state_q == ST_TURN_R);

  assert_right_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN_R && obstacle_i && !clr_i) |=> state_q == ST_TURN_R);

  assert_right_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN_R && !obstacle_i && !clr_i) |=> state_q == ST_CLR_R);

  assert_left_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN_L && !obstacle_i && !clr_i) |=> state_q == ST_HOME);

  assert_clear_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == ST_HOME);
endmodule

// File: tb/obst_steer_ctrl_tb_top.sv
module obst_steer_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       clr_i = 1'b0;
  logic       obstacle_i = 1'b0;
  logic [1:0] turn_o;

  int checks = 0;
  int errors = 0;

  // behavioural model: turning flag plus direction memory
  bit busy = 1'b0;
  bit last_left = 1'b1;
  bit cur_left = 1'b0;

  obst_steer_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .obstacle_i(obstacle_i), .turn_o(turn_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: turn_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_out(input bit x);
    if (!x) return 2'b00;
    if (busy) return cur_left ? 2'b10 : 2'b01;
    return last_left ? 2'b01 : 2'b10;
  endfunction

  function automatic string pick_req(input bit x, input bit c);
    if (c) return "R8";
    if (!x) return "R3";
    if (busy) return cur_left ? "R7" : "R5";
    return last_left ? "R4" : "R6";
  endfunction

  task automatic model_reset();
    busy = 1'b0; last_left = 1'b1; cur_left = 1'b0;
  endtask

  task automatic step(input bit x, input bit c);
    @(negedge clk_i);
    obstacle_i = x;
    clr_i = c;
    #2;
    check(pick_req(x, c), turn_o, model_out(x));
    checks++;
    if (turn_o === 2'b11) begin
      errors++;
      $display("FAIL R2: turn_o=%b expected not 11", turn_o);
    end
    @(posedge clk_i);
    if (c) model_reset();
    else if (x && !busy) begin
      cur_left = !last_left;
      last_left = cur_left;
      busy = 1'b1;
    end else if (!x) busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    bit [7:0] lfsr = 8'hA5;
    #1 rst_ni = 1'b0;
    obstacle_i = 1'b1;
    #2 check("R1", turn_o, 2'b01);  // home during reset
    obstacle_i = 1'b0;
    #1 check("R3", turn_o, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();

    // R4/R5/R6/R7: right, left, right on separate obstacles
    step(0,0); step(1,0); step(1,0); step(1,0); step(0,0);
    step(0,0); step(1,0); step(1,0); step(0,0);
    step(1,0); step(0,0);
    // R9: same-cycle response to a flag change, no edge
    step(1,0);
    @(negedge clk_i);
    obstacle_i = 1'b0;
    #1 check("R9", turn_o, 2'b00);
    obstacle_i = 1'b1;
    #1 check("R9", turn_o, 2'b10);  // still turning left
    @(posedge clk_i);
    step(0,0);                      // back home
    step(1,0);                      // right again (R7)
    // R8: clear in mid obstacle, with obstacle held high
    step(0,0); step(1,0); step(1,1); step(1,0); step(0,0);
    step(1,0); step(1,1); step(0,0); step(1,0);
    // R1: asynchronous reset while turning left
    step(0,0); step(1,0);
    @(negedge clk_i);
    obstacle_i = 1'b1;
    #1 check("R7", turn_o, 2'b10);
    rst_ni = 1'b0;
    #1 check("R1", turn_o, 2'b01);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    obstacle_i = 1'b0;
    step(1,0); step(0,0); step(1,0);

    // mixed runs
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[1], (lfsr[7:3] == 5'd9));
    end
    finish_run();
  end
endmodule